// File: doc/BRIEF.md
# Descriptor Ring Pointer Manager

This block holds the control state of four circular descriptor queues that sit between a packet engine and its driver software. There are two queues per direction. The receive-free queue carries empty buffers from software to hardware. The receive-busy queue returns filled buffers to software. The transmit-busy queue carries frames to be sent. The transmit-reclaim queue returns sent descriptors to software. For every queue the block keeps:

- a start address and a depth;
- a software-owned pointer and a hardware-owned pointer;
- almost-empty and almost-full thresholds.

From these it derives a live occupancy count and four status flags.

Software reaches the state through a simple register port with a write strobe and an asynchronous read. The packet engine moves its own pointer with one strobe per queue, and each pulse steps that pointer by one descriptor. Pointers are exchanged as byte offsets, with one descriptor taking 32 bytes. Writes to the layout fields (start address, depth and the hardware-owned pointer) are guarded by a per-queue enable word. Software sets the matching bit, writes the field, then clears the bit.

No data streams through this block. The strobes and flags are plain level signals with no handshake. A strobe that cannot be honoured is dropped, not stalled, so the engine must watch the flags before it pulses.

Top module: `desc_ring_mgr`

## Requirements
- R1: After reset every queue has start address 0, both pointers 0, depth 1024 descriptors (reads back as 8192), almost-empty threshold 0, almost-full threshold 1023 and enable word 0. Its flags show empty and almost-empty set, and full and almost-full clear.
- R2: Register address bits [4:3] select the queue (0 receive-free, 1 receive-busy, 2 transmit-busy, 3 transmit-reclaim) and bits [2:0] select the field. The field codes are 0 start address, 1 depth, 2 software pointer, 3 hardware pointer, 4 count (read only), 5 almost-empty threshold, 6 almost-full threshold and 7 enable word. A start-address write takes effect only while enable bit 2 is set, and is otherwise ignored.
- R3: Depth is written and read as the descriptor count shifted left by 3. A depth write takes effect only while enable bit 1 is set.
- R4: A CPU write to the hardware pointer takes effect only while enable bit 0 is set. When such a write and an advance strobe fall in the same cycle, the written value wins.
- R5: Pointer fields read and write as byte offsets, with index = offset >> 5. On a software-pointer write the low 5 bits are dropped and the index is reduced modulo the depth.
- R6: In queues 1 and 3 the hardware pointer is the write (producer) pointer. In queues 0 and 2 it is the read (consumer) pointer. An advance strobe moves only the hardware pointer.
- R7: An advance from index depth-1 wraps to index 0.
- R8: The count field reads (write index - read index) modulo depth.
- R9: An advance on a consumer-side hardware pointer is ignored while the queue is empty. An advance on a producer-side hardware pointer is ignored while the queue is full.
- R10: The empty flag means count = 0 and the full flag means count = depth-1, so one slot always stays unused.
- R11: The almost-empty flag means count <= almost-empty threshold and the almost-full flag means count >= almost-full threshold. Both thresholds can be written without any enable bit.
- R12: The enable word (bits [2:0]) is always writable and reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_we | input | 1 | Register write strobe |
| cpu_waddr | input | 5 | Write address: queue in [4:3], field in [2:0] |
| cpu_wdata | input | 32 | Write data |
| cpu_raddr | input | 5 | Read address, same layout as the write address |
| cpu_rdata | output | 32 | Read data, combinational from cpu_raddr |
| hw_adv | input | 4 | One advance pulse per queue for the hardware pointer |
| q_empty | output | 4 | Per-queue empty flag |
| q_full | output | 4 | Per-queue full flag |
| q_alempty | output | 4 | Per-queue almost-empty flag |
| q_alfull | output | 4 | Per-queue almost-full flag |

## Verification
The properties assume that software only programs power-of-two depths of at least two descriptors. With such a depth, empty and full are different counts. They also assume that a cycle with a register write into a queue may move that queue's state arbitrarily, so every stepping property is limited to cycles with no write to the same queue. The stimulus programs only depths of 8 and the reset depth of 1024. It checks the write-versus-strobe collision directly, through the port, rather than through the properties.

// File: rtl/ring_pkg.sv
package ring_pkg;

  localparam int NUM_Q   = 4;
  localparam int QSEL_W  = 2;
  localparam int FIELD_W = 3;
  localparam int REG_AW  = QSEL_W + FIELD_W;

  // Queues whose hardware pointer is the producer (write) side.
  localparam logic [NUM_Q-1:0] HW_PRODUCER_MAP = 4'b1010;

  localparam int DESC_SHIFT  = 5;
  localparam int DEPTH_SHIFT = 3;

  // Bit positions inside the per-queue enable word.
  localparam int EN_HWPTR = 0;
  localparam int EN_DEPTH = 1;
  localparam int EN_BASE  = 2;

  typedef enum logic [FIELD_W-1:0] {
    F_BASE  = 3'd0,
    F_DEPTH = 3'd1,
    F_SWPTR = 3'd2,
    F_HWPTR = 3'd3,
    F_COUNT = 3'd4,
    F_AE_TH = 3'd5,
    F_AF_TH = 3'd6,
    F_REGEN = 3'd7
  } field_e;

endpackage

// File: rtl/ring_regdec.sv
module ring_regdec
  import ring_pkg::*;
(
  input  logic              cpu_we,
  input  logic [REG_AW-1:0] cpu_waddr,
  input  logic [REG_AW-1:0] cpu_raddr,
  output logic [NUM_Q-1:0]  q_we,
  output field_e            wfield,
  output field_e            rfield,
  output logic [QSEL_W-1:0] rsel
);

  assign wfield = field_e'(cpu_waddr[FIELD_W-1:0]);
  assign rfield = field_e'(cpu_raddr[FIELD_W-1:0]);
  assign rsel   = cpu_raddr[REG_AW-1:FIELD_W];

  for (genvar g = 0; g < NUM_Q; g++) begin : g_wsel
    assign q_we[g] = cpu_we && (cpu_waddr[REG_AW-1:FIELD_W] == QSEL_W'(g));
  end

endmodule

// File: rtl/ring_queue.sv
module ring_queue
  import ring_pkg::*;
#(
  parameter int IDX_W       = 10,
  parameter int DATA_W      = 32,
  parameter bit HW_PRODUCER = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  field_e            wfield,
  input  logic [DATA_W-1:0] wdata,
  input  field_e            rfield,
  input  logic              hw_adv,
  output logic [DATA_W-1:0] rdata,
  output logic              empty,
  output logic              full,
  output logic              alempty,
  output logic              alfull
);

  localparam int DW = IDX_W + 1;
  localparam logic [DW-1:0]    DEPTH_RST = DW'(1) << IDX_W;
  localparam logic [IDX_W-1:0] AF_RST    = '1;

  logic [DATA_W-1:0] base_q;
  logic [DW-1:0]     depth_q;
  logic [IDX_W-1:0]  sw_idx, hw_idx;
  logic [IDX_W-1:0]  wr_idx, rd_idx;
  logic [IDX_W-1:0]  mask, count;
  logic [IDX_W-1:0]  ae_th, af_th;
  logic [IDX_W-1:0]  req_idx, hw_next;
  logic [2:0]        regen_q;
  logic              adv_ok;

  // Ring geometry: depth is a power of two, so depth-1 is the wrap mask.
  assign mask    = IDX_W'(depth_q - DW'(1));
  assign req_idx = wdata[IDX_W+DESC_SHIFT-1:DESC_SHIFT] & mask;
  assign hw_next = (hw_idx + IDX_W'(1)) & mask;

  // Ownership: which pointer the engine steps.
  if (HW_PRODUCER) begin : g_hw_prod
    assign wr_idx = hw_idx;
    assign rd_idx = sw_idx;
    assign adv_ok = hw_adv && !full;
  end else begin : g_hw_cons
    assign wr_idx = sw_idx;
    assign rd_idx = hw_idx;
    assign adv_ok = hw_adv && !empty;
  end

  assign count   = (wr_idx - rd_idx) & mask;
  assign empty   = (count == '0);
  assign full    = (count == mask);
  assign alempty = (count <= ae_th);
  assign alfull  = (count >= af_th);

  // Configuration and software pointer.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      depth_q <= DEPTH_RST;
      sw_idx  <= '0;
      ae_th   <= '0;
      af_th   <= AF_RST;
      regen_q <= '0;
    end else if (we) begin
      case (wfield)
        F_BASE:  if (regen_q[EN_BASE])  base_q  <= wdata;
        F_DEPTH: if (regen_q[EN_DEPTH]) depth_q <= wdata[IDX_W+DEPTH_SHIFT:DEPTH_SHIFT];
        F_SWPTR: sw_idx  <= req_idx;
        F_AE_TH: ae_th   <= wdata[IDX_W-1:0];
        F_AF_TH: af_th   <= wdata[IDX_W-1:0];
        F_REGEN: regen_q <= wdata[2:0];
        default: ;
      endcase
    end
  end

  // Hardware pointer: a gated CPU write takes priority over the strobe.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hw_idx <= '0;
    end else if (we && (wfield == F_HWPTR) && regen_q[EN_HWPTR]) begin
      hw_idx <= req_idx;
    end else if (adv_ok) begin
      hw_idx <= hw_next;
    end
  end

  always_comb begin
    case (rfield)
      F_BASE:  rdata = base_q;
      F_DEPTH: rdata = {{(DATA_W-DW-DEPTH_SHIFT){1'b0}}, depth_q, {DEPTH_SHIFT{1'b0}}};
      F_SWPTR: rdata = {{(DATA_W-IDX_W-DESC_SHIFT){1'b0}}, sw_idx, {DESC_SHIFT{1'b0}}};
      F_HWPTR: rdata = {{(DATA_W-IDX_W-DESC_SHIFT){1'b0}}, hw_idx, {DESC_SHIFT{1'b0}}};
      F_COUNT: rdata = {{(DATA_W-IDX_W){1'b0}}, count};
      F_AE_TH: rdata = {{(DATA_W-IDX_W){1'b0}}, ae_th};
      F_AF_TH: rdata = {{(DATA_W-IDX_W){1'b0}}, af_th};
      F_REGEN: rdata = {{(DATA_W-3){1'b0}}, regen_q};
      default: rdata = '0;
    endcase
  end

endmodule

// File: rtl/desc_ring_mgr.sv
module desc_ring_mgr
  import ring_pkg::*;
#(
  parameter int IDX_W  = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_we,
  input  logic [REG_AW-1:0] cpu_waddr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic [REG_AW-1:0] cpu_raddr,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic [NUM_Q-1:0]  hw_adv,
  output logic [NUM_Q-1:0]  q_empty,
  output logic [NUM_Q-1:0]  q_full,
  output logic [NUM_Q-1:0]  q_alempty,
  output logic [NUM_Q-1:0]  q_alfull
);

  logic [NUM_Q-1:0]  q_we;
  field_e            wfield, rfield;
  logic [QSEL_W-1:0] rsel;
  logic [DATA_W-1:0] q_rdata [NUM_Q];

  ring_regdec u_dec (
    .cpu_we    (cpu_we),
    .cpu_waddr (cpu_waddr),
    .cpu_raddr (cpu_raddr),
    .q_we      (q_we),
    .wfield    (wfield),
    .rfield    (rfield),
    .rsel      (rsel)
  );

  for (genvar g = 0; g < NUM_Q; g++) begin : g_q
    ring_queue #(
      .IDX_W       (IDX_W),
      .DATA_W      (DATA_W),
      .HW_PRODUCER (HW_PRODUCER_MAP[g])
    ) u_queue (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (q_we[g]),
      .wfield  (wfield),
      .wdata   (cpu_wdata),
      .rfield  (rfield),
      .hw_adv  (hw_adv[g]),
      .rdata   (q_rdata[g]),
      .empty   (q_empty[g]),
      .full    (q_full[g]),
      .alempty (q_alempty[g]),
      .alfull  (q_alfull[g])
    );
  end

  assign cpu_rdata = q_rdata[rsel];

endmodule

// File: rtl/desc_ring_chk.sv
module desc_ring_chk
  import ring_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_we,
  input logic [REG_AW-1:0] cpu_waddr,
  input logic [NUM_Q-1:0]  hw_adv,
  input logic [NUM_Q-1:0]  q_empty,
  input logic [NUM_Q-1:0]  q_full,
  input logic [NUM_Q-1:0]  q_alempty
);

  for (genvar g = 0; g < NUM_Q; g++) begin : g_chk
    logic touched;
    assign touched = cpu_we && (cpu_waddr[REG_AW-1:FIELD_W] == QSEL_W'(g));

    // R10: with depth >= 2, empty and full are never both set.
    a_r10_distinct: assert property (@(posedge clk) disable iff (!rst_n)
      !(q_empty[g] && q_full[g]));

    // R11: a count of zero is never above the almost-empty threshold.
    a_r11_empty_alempty: assert property (@(posedge clk) disable iff (!rst_n)
      q_empty[g] |-> q_alempty[g]);

    if (HW_PRODUCER_MAP[g]) begin : g_prod
      // R9: producer strobe on a full queue is dropped.
      a_r9_prod_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (q_full[g] && hw_adv[g] && !touched) |=> q_full[g]);
      // R6: a producer step leaves the queue non-empty.
      a_r6_prod_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!q_full[g] && hw_adv[g] && !touched) |=> !q_empty[g]);
    end else begin : g_cons
      // R9: consumer strobe on an empty queue is dropped.
      a_r9_cons_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (q_empty[g] && hw_adv[g] && !touched) |=> q_empty[g]);
      // R6: a consumer step leaves the queue not full.
      a_r6_cons_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!q_empty[g] && hw_adv[g] && !touched) |=> !q_full[g]);
    end
  end

endmodule

bind desc_ring_mgr desc_ring_chk u_desc_ring_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_we    (cpu_we),
  .cpu_waddr (cpu_waddr),
  .hw_adv    (hw_adv),
  .q_empty   (q_empty),
  .q_full    (q_full),
  .q_alempty (q_alempty)
);

// File: tb/test_desc_ring_mgr.sv
module test_desc_ring_mgr;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_we = 1'b0;
  logic [4:0]  cpu_waddr = '0;
  logic [31:0] cpu_wdata = '0;
  logic [4:0]  cpu_raddr = '0;
  logic [31:0] cpu_rdata;
  logic [3:0]  hw_adv = '0;
  logic [3:0]  q_empty, q_full, q_alempty, q_alfull;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  desc_ring_mgr i_desc_ring_mgr (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_waddr(cpu_waddr),
    .cpu_wdata(cpu_wdata), .cpu_raddr(cpu_raddr), .cpu_rdata(cpu_rdata),
    .hw_adv(hw_adv), .q_empty(q_empty), .q_full(q_full),
    .q_alempty(q_alempty), .q_alfull(q_alfull)
  );

  // Vector: kind[74:73] (0 write, 1 read check, 2 strobe), req[72:69],
  // addr[68:64], data[63:32], expected[31:0].
  localparam int NV = 62;
  localparam logic [74:0] VEC [NV] = '{
    {2'd1, 4'd1,  5'd1,  32'd0,      32'd8192},  // R1 depth reset
    {2'd1, 4'd1,  5'd4,  32'd0,      32'd0},     // R1 count
    {2'd1, 4'd1,  5'd6,  32'd0,      32'd1023},  // R1 alfull thresh
    {2'd1, 4'd1,  5'd2,  32'd0,      32'd0},     // R1 sw ptr
    {2'd0, 4'd3,  5'd1,  32'd64,     32'd0},     // R3 ungated depth write
    {2'd1, 4'd3,  5'd1,  32'd0,      32'd8192},  // R3 ignored
    {2'd0, 4'd12, 5'd7,  32'd2,      32'd0},     // R12 enable depth
    {2'd0, 4'd3,  5'd1,  32'd64,     32'd0},     // R3 depth 8
    {2'd0, 4'd12, 5'd7,  32'd0,      32'd0},
    {2'd1, 4'd3,  5'd1,  32'd0,      32'd64},    // R3
    {2'd1, 4'd12, 5'd7,  32'd0,      32'd0},     // R12
    {2'd0, 4'd12, 5'd7,  32'd5,      32'd0},
    {2'd1, 4'd12, 5'd7,  32'd0,      32'd5},     // R12
    {2'd0, 4'd12, 5'd7,  32'd0,      32'd0},
    {2'd0, 4'd2,  5'd0,  32'h1000,   32'd0},     // R2 ungated start
    {2'd1, 4'd2,  5'd0,  32'd0,      32'd0},     // R2
    {2'd0, 4'd2,  5'd7,  32'd4,      32'd0},
    {2'd0, 4'd2,  5'd0,  32'h1000,   32'd0},
    {2'd0, 4'd2,  5'd7,  32'd0,      32'd0},
    {2'd1, 4'd2,  5'd0,  32'd0,      32'h1000},  // R2
    {2'd0, 4'd5,  5'd2,  32'h4B,     32'd0},     // R5 low bits dropped
    {2'd1, 4'd5,  5'd2,  32'd0,      32'h40},    // R5
    {2'd1, 4'd8,  5'd4,  32'd0,      32'd2},     // R8
    {2'd0, 4'd5,  5'd2,  32'h16F,    32'd0},     // R5 index 11 mod 8
    {2'd1, 4'd5,  5'd2,  32'd0,      32'h60},    // R5
    {2'd0, 4'd5,  5'd2,  32'h40,     32'd0},
    {2'd2, 4'd6,  5'd0,  32'd1,      32'd0},     // R6 consumer step
    {2'd1, 4'd6,  5'd3,  32'd0,      32'h20},    // R6
    {2'd1, 4'd8,  5'd4,  32'd0,      32'd1},     // R8
    {2'd2, 4'd9,  5'd0,  32'd1,      32'd0},
    {2'd2, 4'd9,  5'd0,  32'd1,      32'd0},     // R9 empty, dropped
    {2'd1, 4'd9,  5'd3,  32'd0,      32'h40},    // R9
    {2'd1, 4'd9,  5'd4,  32'd0,      32'd0},     // R9
    {2'd0, 4'd4,  5'd3,  32'hE0,     32'd0},     // R4 ungated hw ptr
    {2'd1, 4'd4,  5'd3,  32'd0,      32'h40},    // R4
    {2'd0, 4'd4,  5'd7,  32'd1,      32'd0},
    {2'd0, 4'd4,  5'd3,  32'hE0,     32'd0},
    {2'd0, 4'd4,  5'd7,  32'd0,      32'd0},
    {2'd1, 4'd4,  5'd3,  32'd0,      32'hE0},    // R4
    {2'd1, 4'd8,  5'd4,  32'd0,      32'd3},     // R8 (2-7) mod 8
    {2'd0, 4'd3,  5'd15, 32'd2,      32'd0},
    {2'd0, 4'd3,  5'd9,  32'd64,     32'd0},     // R3 queue 1 depth 8
    {2'd0, 4'd3,  5'd15, 32'd0,      32'd0},
    {2'd2, 4'd9,  5'd0,  32'd2,      32'd0},
    {2'd2, 4'd9,  5'd0,  32'd2,      32'd0},
    {2'd2, 4'd9,  5'd0,  32'd2,      32'd0},
    {2'd2, 4'd9,  5'd0,  32'd2,      32'd0},
    {2'd2, 4'd9,  5'd0,  32'd2,      32'd0},
    {2'd2, 4'd9,  5'd0,  32'd2,      32'd0},
    {2'd2, 4'd9,  5'd0,  32'd2,      32'd0},
    {2'd2, 4'd9,  5'd0,  32'd2,      32'd0},     // R9 full, dropped
    {2'd1, 4'd9,  5'd11, 32'd0,      32'hE0},    // R9
    {2'd1, 4'd9,  5'd12, 32'd0,      32'd7},     // R9
    {2'd1, 4'd6,  5'd10, 32'd0,      32'd0},     // R6 sw ptr untouched
    {2'd0, 4'd8,  5'd10, 32'hC0,     32'd0},
    {2'd1, 4'd8,  5'd12, 32'd0,      32'd1},     // R8
    {2'd2, 4'd7,  5'd0,  32'd2,      32'd0},     // R7 producer wrap
    {2'd1, 4'd7,  5'd11, 32'd0,      32'd0},     // R7
    {2'd1, 4'd7,  5'd12, 32'd0,      32'd2},     // R7
    {2'd2, 4'd7,  5'd0,  32'd1,      32'd0},     // R7 consumer wrap
    {2'd1, 4'd7,  5'd3,  32'd0,      32'd0},     // R7
    {2'd1, 4'd7,  5'd4,  32'd0,      32'd2}      // R7
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    cpu_we = 1'b1; cpu_waddr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic do_adv(input logic [3:0] m);
    @(negedge clk);
    hw_adv = m;
    @(negedge clk);
    hw_adv = '0;
  endtask

  task automatic rd_chk(input string req, input logic [4:0] a, input logic [31:0] exp);
    cpu_raddr = a;
    #1;
    check(req, cpu_rdata, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 / R10 reset flags
    check("R1", {16'd0, q_empty, q_full, q_alempty, q_alfull}, 32'h0000_F0F0);

    for (int i = 0; i < NV; i++) begin
      logic [74:0] v;
      v = VEC[i];
      case (v[74:73])
        2'd0: do_wr(v[68:64], v[63:32]);
        2'd2: do_adv(v[35:32]);
        default: begin
          cpu_raddr = v[68:64];
          #1;
          checks++;
          if (cpu_rdata !== v[31:0]) begin
            failures++;
            $display("FAIL R%0d vec %0d actual=0x%0h expected=0x%0h",
                     v[72:69], i, cpu_rdata, v[31:0]);
          end
        end
      endcase
    end

    // R11: queue 1 holds 2 entries
    do_wr(5'd13, 32'd2);
    do_wr(5'd14, 32'd3);
    rd_chk("R11", 5'd13, 32'd2);
    check("R11", {30'd0, q_alempty[1], q_alfull[1]}, 32'd2);
    do_adv(4'b0010);
    check("R11", {28'd0, q_alempty[1], q_alfull[1], q_full[1], q_empty[1]}, 32'd4);

    // R10: fill queue 1 to depth-1
    for (int k = 0; k < 4; k++) do_adv(4'b0010);
    check("R10", {30'd0, q_full[1], q_empty[1]}, 32'd2);
    do_adv(4'b0010);
    rd_chk("R9", 5'd12, 32'd7);

    // R4: CPU write beats same-cycle strobe on queue 0 (rd 0, wr 2)
    do_wr(5'd7, 32'd1);
    @(negedge clk);
    cpu_we = 1'b1; cpu_waddr = 5'd3; cpu_wdata = 32'h40; hw_adv = 4'b0001;
    @(negedge clk);
    cpu_we = 1'b0; hw_adv = '0;
    do_wr(5'd7, 32'd0);
    rd_chk("R4", 5'd3, 32'h40);
    check("R10", {31'd0, q_empty[0]}, 32'd1);

    // R6: queue 3 hardware pointer is the producer
    do_adv(4'b1000);
    rd_chk("R6", 5'd27, 32'h20);
    rd_chk("R8", 5'd28, 32'd1);
    check("R10", {30'd0, q_empty[3], q_empty[2]}, 32'd1);

    finish_run();
  end

endmodule